// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Context Tags

This block is the main translation buffer of a processor's memory management unit. It holds recently used mappings from 32-bit virtual addresses to physical addresses in a 4-way set-associative array of flip-flops. Each entry holds a virtual tag and a 9-bit context tag. A global flag lets the entry match under every context. A size flag makes the entry map either a 4KB page or a 1MB page. The entry also holds the physical page number, dirty, executable and accessed flags, a 3-bit cache-policy code and a 3-bit privilege code. A lookup returns hit, the physical address and the attribute codes one cycle later, together with execute and dirty faults.

Entries are written through a fill port, which is used by software or by a page walker. The fill port picks its own victim way. A per-entry lock keeps an entry out of replacement and out of global invalidation. A single-cycle invalidate pulse clears every unlocked entry. 4KB entries are indexed by VA[12+:SETW]. 1MB entries are indexed by VA[20+:SETW]. A lookup probes both candidate sets in parallel, so 8 tag compares run in one cycle.

The lookup port is a valid/ready stream. `lk_ready` is low in every cycle where `fl_valid` is high, so a fill always wins that cycle. A request that is held off must be presented again by the requester and gets no response. The response has no back-pressure: `rsp_valid` pulses for exactly one cycle. The fill port is a valid/ready stream whose ready is always high.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid. `rsp_valid` and `fl_err` are low, and every lookup misses.
- R2: An accepted lookup produces `rsp_valid` in the next cycle. A 4KB entry hits when it is valid, its size flag is 0 and its 20-bit tag equals VA[31:12]. The result is PA = {PPN, VA[11:0]}, with the stored cache-policy and privilege codes. When several entries match, the 4KB set wins over the 1MB set, and a lower way wins over a higher one.
- R3: A 1MB entry has its size flag at 1. It compares only VA[31:20] against tag bits [19:8] and gives PA = {PPN[19:8], VA[19:0]}.
- R4: An entry with the global flag set matches under any context. Any other entry matches only when its stored context equals `lk_cid`.
- R5: Access codes are 0 = load, 1 = store, 2 = fetch, and 3 = load. A fetch that hits an entry with executable = 0 raises `rsp_xfault`. A store that hits an entry with dirty = 0 raises `rsp_dfault`. A load raises neither fault.
- R6: A miss returns `rsp_hit` = 0 with both faults low.
- R7: A fill writes into the lowest-numbered invalid way of its set, and it leaves that set's rotation pointer unchanged.
- R8: A fill into a set with all four ways valid starts at the set's rotation pointer (0 after reset). It takes the first way, counting upward with wrap, that is not locked. Afterwards the pointer is set to that way plus 1.
- R9: A fill into a set whose four ways are all valid and locked is dropped, and `fl_err` pulses high in the next cycle. The set's contents do not change.
- R10: `inv_all` clears every unlocked entry and keeps locked ones. A fill presented in the same cycle is written after the clear, so the new entry survives.
- R11: `lk_ready` is low while `fl_valid` is high. A request that is not accepted produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_cid | input | 9 | Current context |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 32 | Physical address |
| rsp_c | output | 3 | Cache-policy code of the hit entry |
| rsp_m | output | 3 | Privilege code of the hit entry |
| rsp_xfault | output | 1 | Fetch from non-executable page |
| rsp_dfault | output | 1 | Store to page whose dirty flag is clear |
| fl_valid | input | 1 | Fill request valid |
| fl_ready | output | 1 | Fill accepted (always high) |
| fl_va | input | 32 | Virtual address of new entry |
| fl_cid | input | 9 | Context of new entry |
| fl_glob | input | 1 | Global flag |
| fl_huge | input | 1 | 1MB page flag |
| fl_lock | input | 1 | Lock flag |
| fl_ppn | input | 20 | Physical page number |
| fl_dirty | input | 1 | Dirty flag |
| fl_exec | input | 1 | Executable flag |
| fl_used | input | 1 | Accessed flag |
| fl_cache | input | 3 | Cache-policy code |
| fl_priv | input | 3 | Privilege code |
| fl_err | output | 1 | Pulse: fill dropped, set fully locked |
| inv_all | input | 1 | Global invalidate of unlocked entries |

## Verification
Two pairs of functions can fall in the same cycle. A fill can collide with a lookup, and a fill can collide with a global invalidate. The bench drives `fl_valid` and `lk_valid` in the same cycle and expects `lk_ready` low and no response in the following cycle. It also drives a fill together with `inv_all`, then probes with lookups: unlocked old mappings must miss, while the locked ones and the new entry must hit. Random fills, lookups and invalidates over a few crowded sets are checked against a bench model built from the requirements.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int WAYS = 4;
  localparam int WAYW = 2;
  localparam int VPNW = 20;
  localparam int CIDW = 9;
  localparam int HUGE_LSB = 8;  // tag bits below this are ignored for 1MB pages

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

  typedef struct packed {
    logic            vld;
    logic            lock;
    logic            glob;
    logic            huge;
    logic [CIDW-1:0] cid;
    logic [VPNW-1:0] vpn;
    logic [VPNW-1:0] ppn;
    logic            dirty;
    logic            exec;
    logic            used;
    logic [2:0]      cache;
    logic [2:0]      priv;
  } ent_t;
endpackage

// File: rtl/ctx_tlb_cmp.sv
module ctx_tlb_cmp
  import ctx_tlb_pkg::*;
#(
  parameter bit HUGE = 1'b0
) (
  input  ent_t            ent,
  input  logic [VPNW-1:0] vpn,
  input  logic [CIDW-1:0] cid,
  output logic            hit
);
  logic tag_eq;
  logic ctx_eq;

  generate
    if (HUGE) begin : g_big
      assign tag_eq = (ent.vpn[VPNW-1:HUGE_LSB] == vpn[VPNW-1:HUGE_LSB]);
    end else begin : g_small
      assign tag_eq = (ent.vpn == vpn);
    end
  endgenerate

  assign ctx_eq = ent.glob | (ent.cid == cid);
  assign hit    = ent.vld & (ent.huge == HUGE) & tag_eq & ctx_eq;
endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim
  import ctx_tlb_pkg::*;
(
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] locked,
  input  logic [WAYW-1:0] ptr,
  output logic [WAYW-1:0] vic,
  output logic            vic_ok,
  output logic            vic_free
);
  logic [WAYW-1:0] idx;

  always_comb begin
    vic      = '0;
    vic_ok   = 1'b0;
    vic_free = 1'b0;
    idx      = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        vic      = WAYW'(i);
        vic_free = 1'b1;
      end
    end
    if (vic_free) begin
      vic_ok = 1'b1;
    end else begin
      for (int k = WAYS - 1; k >= 0; k--) begin
        idx = ptr + WAYW'(k);
        if (!locked[idx]) begin
          vic    = idx;
          vic_ok = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int SETS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_va,
  input  logic [8:0]  lk_cid,
  input  logic [1:0]  lk_acc,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [31:0] rsp_pa,
  output logic [2:0]  rsp_c,
  output logic [2:0]  rsp_m,
  output logic        rsp_xfault,
  output logic        rsp_dfault,
  input  logic        fl_valid,
  output logic        fl_ready,
  input  logic [31:0] fl_va,
  input  logic [8:0]  fl_cid,
  input  logic        fl_glob,
  input  logic        fl_huge,
  input  logic        fl_lock,
  input  logic [19:0] fl_ppn,
  input  logic        fl_dirty,
  input  logic        fl_exec,
  input  logic        fl_used,
  input  logic [2:0]  fl_cache,
  input  logic [2:0]  fl_priv,
  output logic        fl_err,
  input  logic        inv_all
);
  localparam int SETW    = $clog2(SETS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDXW    = SETW + WAYW;
  localparam int SML_LSB = 12;
  localparam int BIG_LSB = 20;

  ent_t            ent_q [ENTRIES];
  logic [WAYW-1:0] rr_q  [SETS];

  // ---------------- lookup ----------------
  logic [SETW-1:0] s_set, b_set;
  logic [WAYS-1:0] s_hit, b_hit;
  ent_t            s_ent [WAYS];
  ent_t            b_ent [WAYS];
  logic            lk_go;

  assign s_set    = lk_va[SML_LSB +: SETW];
  assign b_set    = lk_va[BIG_LSB +: SETW];
  assign lk_ready = ~fl_valid;
  assign fl_ready = 1'b1;
  assign lk_go    = lk_valid & lk_ready;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAYW-1:0] WI = WAYW'(w);
      assign s_ent[w] = ent_q[{s_set, WI}];
      assign b_ent[w] = ent_q[{b_set, WI}];
      ctx_tlb_cmp #(.HUGE(1'b0)) u_small (
        .ent(s_ent[w]), .vpn(lk_va[31:12]), .cid(lk_cid), .hit(s_hit[w]));
      ctx_tlb_cmp #(.HUGE(1'b1)) u_big (
        .ent(b_ent[w]), .vpn(lk_va[31:12]), .cid(lk_cid), .hit(b_hit[w]));
    end
  endgenerate

  logic        sel_hit;
  logic [31:0] sel_pa;
  ent_t        sel_ent;

  always_comb begin
    sel_hit = 1'b0;
    sel_ent = '0;
    sel_pa  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (b_hit[w]) begin
        sel_hit = 1'b1;
        sel_ent = b_ent[w];
        sel_pa  = {b_ent[w].ppn[VPNW-1:HUGE_LSB], lk_va[19:0]};
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (s_hit[w]) begin
        sel_hit = 1'b1;
        sel_ent = s_ent[w];
        sel_pa  = {s_ent[w].ppn, lk_va[11:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_pa     <= '0;
      rsp_c      <= '0;
      rsp_m      <= '0;
      rsp_xfault <= 1'b0;
      rsp_dfault <= 1'b0;
    end else begin
      rsp_valid  <= lk_go;
      rsp_hit    <= lk_go & sel_hit;
      rsp_pa     <= sel_pa;
      rsp_c      <= sel_ent.cache;
      rsp_m      <= sel_ent.priv;
      rsp_xfault <= lk_go & sel_hit & (acc_e'(lk_acc) == ACC_FETCH) & ~sel_ent.exec;
      rsp_dfault <= lk_go & sel_hit & (acc_e'(lk_acc) == ACC_STORE) & ~sel_ent.dirty;
    end
  end

  // ---------------- fill ----------------
  logic [SETW-1:0] f_set;
  logic [WAYS-1:0] f_valid, f_locked;
  logic [WAYW-1:0] vic;
  logic            vic_ok, vic_free;
  ent_t            f_new;

  assign f_set = fl_huge ? fl_va[BIG_LSB +: SETW] : fl_va[SML_LSB +: SETW];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      f_valid[w]  = ent_q[{f_set, WAYW'(w)}].vld;
      f_locked[w] = ent_q[{f_set, WAYW'(w)}].vld & ent_q[{f_set, WAYW'(w)}].lock;
    end
  end

  ctx_tlb_victim u_victim (
    .valid(f_valid), .locked(f_locked), .ptr(rr_q[f_set]),
    .vic(vic), .vic_ok(vic_ok), .vic_free(vic_free));

  always_comb begin
    f_new       = '0;
    f_new.vld   = 1'b1;
    f_new.lock  = fl_lock;
    f_new.glob  = fl_glob;
    f_new.huge  = fl_huge;
    f_new.cid   = fl_cid;
    f_new.vpn   = fl_va[31:12];
    f_new.ppn   = fl_ppn;
    f_new.dirty = fl_dirty;
    f_new.exec  = fl_exec;
    f_new.used  = fl_used;
    f_new.cache = fl_cache;
    f_new.priv  = fl_priv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) ent_q[e] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      fl_err <= 1'b0;
    end else begin
      if (inv_all) begin
        for (int e = 0; e < ENTRIES; e++)
          if (!ent_q[e].lock) ent_q[e].vld <= 1'b0;
      end
      if (fl_valid && vic_ok) begin
        ent_q[{f_set, vic}] <= f_new;
        if (!vic_free) rr_q[f_set] <= vic + WAYW'(1);
      end
      fl_err <= fl_valid & ~vic_ok;
    end
  end

  // ---------------- assertions ----------------
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid) else $error("rsp missing"); // R2
  AST_NO_RSP_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> !rsp_valid) else $error("rsp while held"); // R11
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_xfault || rsp_dfault) |-> (rsp_hit && rsp_valid)) else $error("fault w/o hit"); // R6
  AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && (f_valid != '1)) |-> !f_valid[vic]) else $error("free way skipped"); // R7
  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && vic_ok) |-> !f_locked[vic]) else $error("locked victim"); // R8
  AST_ERR_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fl_err |-> $past(fl_valid)) else $error("stray err"); // R9
endmodule

// File: tb/test_ctx_tlb.sv
`timescale 1ns/1ps
module test_ctx_tlb;
  import ctx_tlb_pkg::*;
  localparam int SETS = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_ready;
  logic [31:0] lk_va = 0;
  logic [8:0] lk_cid = 0;
  logic [1:0] lk_acc = 0;
  logic rsp_valid, rsp_hit, rsp_xfault, rsp_dfault;
  logic [31:0] rsp_pa;
  logic [2:0] rsp_c, rsp_m;
  logic fl_valid = 0, fl_ready, fl_glob = 0, fl_huge = 0, fl_lock = 0;
  logic fl_dirty = 0, fl_exec = 0, fl_used = 0, fl_err, inv_all = 0;
  logic [31:0] fl_va = 0;
  logic [8:0] fl_cid = 0;
  logic [19:0] fl_ppn = 0;
  logic [2:0] fl_cache = 0, fl_priv = 0;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_tlb #(.SETS(SETS)) i_ctx_tlb (.*);

  // bench model
  ent_t mv [SETS*WAYS];
  logic [1:0] mrr [SETS];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] ref_lookup(input logic [31:0] va, input logic [8:0] cid,
                                            input logic [1:0] acc);
    int ss = int'(va[16:12]);
    int bs = int'(va[24:20]);
    for (int w = 0; w < WAYS; w++) begin
      ent_t e = mv[ss*WAYS+w];
      if (e.vld && !e.huge && e.vpn == va[31:12] && (e.glob || e.cid == cid))
        return {1'b1, e.ppn, va[11:0], e.cache, e.priv,
                acc == 2'd2 && !e.exec, acc == 2'd1 && !e.dirty};
    end
    for (int w = 0; w < WAYS; w++) begin
      ent_t e = mv[bs*WAYS+w];
      if (e.vld && e.huge && e.vpn[19:8] == va[31:20] && (e.glob || e.cid == cid))
        return {1'b1, e.ppn[19:8], va[19:0], e.cache, e.priv,
                acc == 2'd2 && !e.exec, acc == 2'd1 && !e.dirty};
    end
    return '0;
  endfunction

  task automatic m_fill(output bit err);
    int s = fl_huge ? int'(fl_va[24:20]) : int'(fl_va[16:12]);
    int way = -1;
    ent_t n;
    err = 0;
    for (int w = WAYS - 1; w >= 0; w--) if (!mv[s*WAYS+w].vld) way = w;
    if (way < 0) begin
      for (int k = WAYS - 1; k >= 0; k--) begin
        int idx = (int'(mrr[s]) + k) % WAYS;
        if (!mv[s*WAYS+idx].lock) way = idx;
      end
      if (way >= 0) mrr[s] = 2'((way + 1) % WAYS);
    end
    if (way < 0) begin err = 1; return; end
    n = '0;
    n.vld = 1; n.lock = fl_lock; n.glob = fl_glob; n.huge = fl_huge; n.cid = fl_cid;
    n.vpn = fl_va[31:12]; n.ppn = fl_ppn; n.dirty = fl_dirty; n.exec = fl_exec;
    n.used = fl_used; n.cache = fl_cache; n.priv = fl_priv;
    mv[s*WAYS+way] = n;
  endtask

  task automatic m_inv();
    for (int e = 0; e < SETS*WAYS; e++) if (!mv[e].lock) mv[e].vld = 0;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [8:0] cid,
                        input logic [1:0] acc);
    logic [40:0] exp = ref_lookup(va, cid, acc);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_cid = cid; lk_acc = acc;
    @(negedge clk);
    lk_valid = 0;
    chk(req, {rsp_valid, rsp_hit, rsp_pa, rsp_c, rsp_m, rsp_xfault, rsp_dfault},
        {1'b1, exp});
  endtask

  task automatic fill(input string req, input logic [31:0] va, input logic [8:0] cid,
                      input bit g, input bit h, input bit lk, input logic [19:0] ppn,
                      input bit d, input bit x, input logic [2:0] c, input logic [2:0] m,
                      input bit with_inv);
    bit err;
    @(negedge clk);
    fl_valid = 1; fl_va = va; fl_cid = cid; fl_glob = g; fl_huge = h; fl_lock = lk;
    fl_ppn = ppn; fl_dirty = d; fl_exec = x; fl_used = 1; fl_cache = c; fl_priv = m;
    inv_all = with_inv;
    if (with_inv) m_inv();
    m_fill(err);
    @(negedge clk);
    fl_valid = 0; inv_all = 0;
    chk(req, 64'(fl_err), 64'(err));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int e = 0; e < SETS*WAYS; e++) mv[e] = '0;
    for (int s = 0; s < SETS; s++) mrr[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {rsp_valid, fl_err, lk_ready}, 3'b001);
    lookup("R1 miss after reset", 32'h1234_5678, 9'd5, 2'd0);

    // R2 small page
    fill("R2 fill", 32'h1234_5000, 9'd5, 0, 0, 0, 20'hABCDE, 1, 1, 3'd3, 3'd5, 0);
    lookup("R2 hit small", 32'h1234_5678, 9'd5, 2'd0);
    chk("R2 pa value", rsp_pa, 32'hABCD_E678);
    // R4 context
    lookup("R4 other cid miss", 32'h1234_5678, 9'd6, 2'd0);
    fill("R4 fill global", 32'h0000_2000, 9'd1, 1, 0, 0, 20'h11111, 1, 1, 3'd1, 3'd2, 0);
    lookup("R4 global any cid", 32'h0000_2ABC, 9'd300, 2'd0);
    chk("R4 global hit", 64'(rsp_hit), 64'd1);
    // R3 1MB page
    fill("R3 fill", 32'h7F50_0000, 9'd2, 0, 1, 0, 20'h33300, 1, 1, 3'd6, 3'd1, 0);
    lookup("R3 hit big", 32'h7F5A_BCDE, 9'd2, 2'd0);
    chk("R3 pa value", rsp_pa, 32'h333A_BCDE);
    // R5 faults
    fill("R5 fill", 32'h4000_3000, 9'd7, 0, 0, 0, 20'h55555, 0, 0, 3'd0, 3'd0, 0);
    lookup("R5 fetch xfault", 32'h4000_3010, 9'd7, 2'd2);
    chk("R5 xfault", {rsp_xfault, rsp_dfault}, 2'b10);
    lookup("R5 store dfault", 32'h4000_3010, 9'd7, 2'd1);
    chk("R5 dfault", {rsp_xfault, rsp_dfault}, 2'b01);
    lookup("R5 load no fault", 32'h4000_3010, 9'd7, 2'd0);
    lookup("R6 miss fetch", 32'h9000_3010, 9'd7, 2'd2);
    chk("R6 miss no fault", {rsp_hit, rsp_xfault, rsp_dfault}, 3'b000);

    // R7/R8 set 9: four fills, second locked
    for (int i = 0; i < 4; i++)
      fill("R7 fill free", {4'(i + 1), 11'd0, 5'd9, 12'd0}, 9'd0, 0, 0, i == 1,
           20'(i), 1, 1, 3'd0, 3'd0, 0);
    fill("R8 fill rr0", {4'd8, 11'd0, 5'd9, 12'd0}, 9'd0, 0, 0, 0, 20'h8, 1, 1, 3'd0, 3'd0, 0);
    fill("R8 fill rr1", {4'd9, 11'd0, 5'd9, 12'd0}, 9'd0, 0, 0, 0, 20'h9, 1, 1, 3'd0, 3'd0, 0);
    lookup("R8 way0 replaced", {4'd1, 11'd0, 5'd9, 12'd0}, 9'd0, 2'd0);
    chk("R8 way0 miss", 64'(rsp_hit), 64'd0);
    lookup("R8 locked kept", {4'd2, 11'd0, 5'd9, 12'd0}, 9'd0, 2'd0);
    chk("R8 locked hit", 64'(rsp_hit), 64'd1);
    lookup("R8 way2 replaced", {4'd3, 11'd0, 5'd9, 12'd0}, 9'd0, 2'd0);
    lookup("R7 way3 kept", {4'd4, 11'd0, 5'd9, 12'd0}, 9'd0, 2'd0);

    // R9 fully locked set 11
    for (int i = 0; i < 4; i++)
      fill("R9 fill lock", {4'(i + 1), 11'd0, 5'd11, 12'd0}, 9'd0, 0, 0, 1,
           20'(i + 16), 1, 1, 3'd0, 3'd0, 0);
    fill("R9 dropped", {4'd12, 11'd0, 5'd11, 12'd0}, 9'd0, 0, 0, 0, 20'h77, 1, 1, 3'd0, 3'd0, 0);
    chk("R9 err pulse", 64'(fl_err), 64'd1);
    for (int i = 0; i < 4; i++)
      lookup("R9 contents kept", {4'(i + 1), 11'd0, 5'd11, 12'd0}, 9'd0, 2'd0);
    lookup("R9 dropped absent", {4'd12, 11'd0, 5'd11, 12'd0}, 9'd0, 2'd0);

    // R10 invalidate with simultaneous fill
    fill("R10 inv+fill", 32'h6660_1000, 9'd3, 0, 0, 0, 20'h12345, 1, 1, 3'd2, 3'd2, 1);
    lookup("R10 new kept", 32'h6660_1000, 9'd3, 2'd0);
    chk("R10 new hit", 64'(rsp_hit), 64'd1);
    lookup("R10 unlocked gone", 32'h1234_5678, 9'd5, 2'd0);
    chk("R10 unlocked miss", 64'(rsp_hit), 64'd0);
    lookup("R10 locked kept", {4'd2, 11'd0, 5'd9, 12'd0}, 9'd0, 2'd0);

    // R11 lookup and fill in the same cycle
    begin
      bit err;
      @(negedge clk);
      lk_valid = 1; lk_va = 32'h6660_1000; lk_cid = 9'd3; lk_acc = 0;
      fl_valid = 1; fl_va = 32'h2220_4000; fl_cid = 9'd1; fl_glob = 0; fl_huge = 0;
      fl_lock = 0; fl_ppn = 20'h2; fl_dirty = 1; fl_exec = 1;
      m_fill(err);
      #1 chk("R11 ready low", 64'(lk_ready), 64'd0);
      @(negedge clk);
      fl_valid = 0; lk_valid = 0;
      chk("R11 no response", 64'(rsp_valid), 64'd0);
    end
    lookup("R11 fill applied", 32'h2220_4000, 9'd1, 2'd0);

    // random phase over crowded sets
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 99);
      bit h = ($urandom_range(0, 3) == 0);
      logic [31:0] va;
      if (h) va = (32'($urandom_range(0, 7)) << 25) | (32'($urandom_range(0, 3)) << 20)
                  | 32'($urandom_range(0, 32'hFFFFF));
      else   va = (32'($urandom_range(0, 7)) << 24) | (32'($urandom_range(0, 3)) << 12)
                  | 32'($urandom_range(0, 32'hFFF));
      if (op < 40)
        fill("R8 random fill", va, 9'($urandom_range(0, 3)), $urandom_range(0, 3) == 0, h,
             $urandom_range(0, 9) == 0, 20'($urandom), 1'($urandom), 1'($urandom),
             3'($urandom), 3'($urandom), 0);
      else if (op < 97)
        lookup("R2 random lookup", va, 9'($urandom_range(0, 3)), 2'($urandom));
      else begin
        @(negedge clk); inv_all = 1; m_inv();
        @(negedge clk); inv_all = 0;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule